// File: doc/BRIEF.md
# Prescaled 8-Bit Event Timer

This block is an 8-bit up-counter whose count source is picked by a 3-bit select code. The code can choose one of three fixed divisions of the system clock, a divide-by-four of a slow sub-clock, or the edges of an external event input. For event counting, a polarity bit decides whether rising or falling edges count. Both the sub-clock and the event input are synchronized into the system clock domain. The counter never runs on a derived clock. It moves by one on single-cycle enable pulses.

The counter is compared with a compare register. An overflow flag and a match flag record wraps and matches, and both are sticky. Software clears a flag by first reading it as 1 and then writing 0 to its bit. An overflow interrupt request is raised while the overflow flag is set and its enable bit is on. A small strobe-based register bus gives access to the control, compare, status and count registers. Reads return data combinationally in the strobe cycle.

Top module: `prescaled_timer8`

## Requirements
- R1: After reset the count is 0, the control register reads 0x00, the compare register reads 0xFF, the status register reads 0x00 and irqOvf is low.
- R2: Select codes 100, 101 and 110 advance the count once every 32, 16 and 4 system clock cycles respectively, so any 128-cycle window adds 4, 8 or 32.
- R3: Select code 111 advances the count once for every four rising edges of subClk.
- R4: Select codes 000, 001 and 010 count edges of evtIn. With control bit 3 at 1 only rising edges count. With control bit 3 at 0 only falling edges count. The other edge leaves the count unchanged.
- R5: Select code 011 stops counting. Neither evtIn nor subClk nor time changes the count.
- R6: When the count advances from 0xFF it becomes 0x00 and the overflow flag (status bit 7) is set.
- R7: When the count advances to a value equal to the compare register, the match flag (status bit 6) is set.
- R8: A flag clears only on a status write with 0 in its bit, made after a status read that returned that flag as 1. A write of 0 with no such read, or a write of 1, leaves the flag set.
- R9: If a flag's set condition and its software clear fall in the same cycle, the flag stays set.
- R10: irqOvf is high exactly when the overflow flag and the interrupt enable (status bit 0) are both 1.
- R11: Register map on addr: 0 is control, with bits [2:0] the select code and bit 3 the edge polarity. 1 is compare. 2 is status. 3 is the count, which is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe, one cycle |
| wrEn | input | 1 | Write strobe, one cycle |
| addr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdEn is high |
| evtIn | input | 1 | External event input, asynchronous |
| subClk | input | 1 | Slow sub-clock, sampled as data |
| irqOvf | output | 1 | Overflow interrupt request |

## Verification
A wrong divide tap or a bad source decode shows up as a wrong count delta within one 128-cycle window read through address 3. A synchronizer latency error moves the cycle in which the count changes, and the same-cycle set/clear test is timed to that exact edge. A flag or arming latch in the wrong state shows on irqOvf or on the status read at the very next bus access, because each clear attempt is followed at once by an observation.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  typedef enum logic [2:0] {
    SRC_EVT_A = 3'b000,
    SRC_EVT_B = 3'b001,
    SRC_EVT_C = 3'b010,
    SRC_OFF   = 3'b011,
    SRC_DIV32 = 3'b100,
    SRC_DIV16 = 3'b101,
    SRC_DIV4  = 3'b110,
    SRC_SUB4  = 3'b111
  } srcSel_e;

  // control -> datapath strobes
  typedef struct packed {
    srcSel_e srcSel;
    logic    riseEdge;
  } dpCtrl_t;

  // datapath -> control events
  typedef struct packed {
    logic wrapPulse;
    logic matchPulse;
  } dpEvt_t;

endpackage

// File: rtl/timer8_edge_sync.sv
module timer8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic syncQ,
  output logic prevQ
);

  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      prevQ  <= 1'b0;
    end else begin
      shiftQ <= {shiftQ[STAGES-2:0], din};
      prevQ  <= shiftQ[STAGES-1];
    end
  end

  assign syncQ = shiftQ[STAGES-1];

endmodule

// File: rtl/timer8_dp.sv
module timer8_dp
  import timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SUB_DIV_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtIn,
  input  logic             subClk,
  input  dpCtrl_t          ctl,
  input  logic [CNT_W-1:0] cmpVal,
  output dpEvt_t           evt,
  output logic [CNT_W-1:0] count
);

  localparam int SHIFT_HI  = 5;   // log2(32)
  localparam int SHIFT_MID = 4;   // log2(16)
  localparam int SHIFT_LO  = 2;   // log2(4)

  logic [SHIFT_HI-1:0]  preQ;
  logic [SUB_DIV_W-1:0] subDivQ;
  logic [CNT_W-1:0]     cntQ;
  logic [CNT_W-1:0]     cntNext;
  logic evtSync, evtPrev, subSync, subPrev;
  logic evtRise, evtFall, subRise, subTick;
  logic tickHi, tickMid, tickLo, step;

  timer8_edge_sync #(.STAGES(SYNC_STAGES)) u_evtSync (
    .clk(clk), .rstN(rstN), .din(evtIn), .syncQ(evtSync), .prevQ(evtPrev)
  );

  timer8_edge_sync #(.STAGES(SYNC_STAGES)) u_subSync (
    .clk(clk), .rstN(rstN), .din(subClk), .syncQ(subSync), .prevQ(subPrev)
  );

  assign evtRise = evtSync & ~evtPrev;
  assign evtFall = ~evtSync & evtPrev;
  assign subRise = subSync & ~subPrev;
  assign subTick = subRise & (&subDivQ);

  // free-running system clock prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preQ <= '0;
    else       preQ <= preQ + 1'b1;
  end

  assign tickHi  = &preQ[SHIFT_HI-1:0];
  assign tickMid = &preQ[SHIFT_MID-1:0];
  assign tickLo  = &preQ[SHIFT_LO-1:0];

  // sub-clock edge divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        subDivQ <= '0;
    else if (subRise) subDivQ <= subDivQ + 1'b1;
  end

  always_comb begin
    unique case (ctl.srcSel)
      SRC_EVT_A, SRC_EVT_B, SRC_EVT_C: step = ctl.riseEdge ? evtRise : evtFall;
      SRC_OFF:   step = 1'b0;
      SRC_DIV32: step = tickHi;
      SRC_DIV16: step = tickMid;
      SRC_DIV4:  step = tickLo;
      SRC_SUB4:  step = subTick;
      default:   step = 1'b0;
    endcase
  end

  assign cntNext = cntQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cntQ <= '0;
    else if (step) cntQ <= cntNext;
  end

  assign evt.wrapPulse  = step & (&cntQ);
  assign evt.matchPulse = step & (cntNext == cmpVal);
  assign count          = cntQ;

endmodule

// File: rtl/timer8_ctrl.sv
module timer8_ctrl
  import timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  dpEvt_t           evt,
  input  logic [CNT_W-1:0] count,
  output dpCtrl_t          ctl,
  output logic [CNT_W-1:0] cmpVal,
  output logic             ovfFlag,
  output logic             cmfFlag,
  output logic             irqOvf
);

  localparam int NUM_FLAGS = 2;   // index 1: overflow, index 0: match
  localparam int IE_BIT    = 0;

  logic [2:0]           selQ;
  logic                 riseQ;
  logic [CNT_W-1:0]     cmpQ;
  logic                 ieQ;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] setIn;
  logic                 wrCtrl, wrCmp, wrStat, rdStat;

  assign wrCtrl = wrEn && (addr == ADDR_CTRL);
  assign wrCmp  = wrEn && (addr == ADDR_CMP);
  assign wrStat = wrEn && (addr == ADDR_STAT);
  assign rdStat = rdEn && (addr == ADDR_STAT);
  assign setIn  = {evt.wrapPulse, evt.matchPulse};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      riseQ <= 1'b0;
      cmpQ  <= '1;
      ieQ   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        selQ  <= wrData[2:0];
        riseQ <= wrData[3];
      end
      if (wrCmp)  cmpQ <= wrData;
      if (wrStat) ieQ  <= wrData[IE_BIT];
    end
  end

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    localparam int BitPos = CNT_W - 2 + gi;
    logic fQ, armQ, clrReq, armReq;

    assign clrReq = wrStat && !wrData[BitPos] && armQ;
    assign armReq = rdStat && fQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fQ   <= 1'b0;
        armQ <= 1'b0;
      end else if (setIn[gi]) begin
        fQ   <= 1'b1;               // hardware set wins
        armQ <= armQ | armReq;
      end else if (clrReq) begin
        fQ   <= 1'b0;
        armQ <= 1'b0;
      end else begin
        armQ <= armQ | armReq;
      end
    end

    assign flagQ[gi] = fQ;
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: rdData[3:0] = {riseQ, selQ};
      ADDR_CMP:  rdData = cmpQ;
      ADDR_STAT: begin
        rdData[CNT_W-1:CNT_W-2] = flagQ;
        rdData[IE_BIT]          = ieQ;
      end
      ADDR_CNT:  rdData = count;
      default:   rdData = '0;
    endcase
  end

  assign ctl.srcSel   = srcSel_e'(selQ);
  assign ctl.riseEdge = riseQ;
  assign cmpVal       = cmpQ;
  assign ovfFlag      = flagQ[1];
  assign cmfFlag      = flagQ[0];
  assign irqOvf       = flagQ[1] & ieQ;

endmodule

// File: rtl/prescaled_timer8.sv
module prescaled_timer8
  import timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic             evtIn,
  input  logic             subClk,
  output logic             irqOvf
);

  dpCtrl_t          dpCtl;
  dpEvt_t           dpEvt;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] cmpVal;
  logic             ovfFlag, cmfFlag;

  timer8_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evt(dpEvt), .count(countQ),
    .ctl(dpCtl), .cmpVal(cmpVal), .ovfFlag(ovfFlag), .cmfFlag(cmfFlag),
    .irqOvf(irqOvf)
  );

  timer8_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .subClk(subClk),
    .ctl(dpCtl), .cmpVal(cmpVal), .evt(dpEvt), .count(countQ)
  );

endmodule

// File: rtl/timer8_checker.sv
module timer8_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpVal,
  input logic [2:0]       srcSel,
  input logic             ovfFlag,
  input logic             cmfFlag
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R2: the count only ever moves forward by one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cnt) |-> cnt == ($past(cnt) + ONE));

  // R5: reserved code freezes the count
  a_r5_reserved_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(srcSel) == 3'b011) |-> $stable(cnt));

  // R6: wrap sets overflow
  a_r6_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cnt) == {CNT_W{1'b1}} && cnt == '0) |-> ovfFlag);

  // R7: reaching the compare value sets the match flag
  a_r7_match_sets_cmf: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(cnt) && $stable(cmpVal) && cnt == cmpVal) |-> cmfFlag);

  // R8: a flag falls only after a status write of 0 to its bit
  a_r8_ovf_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(wrEn && addr == 2'd2 && !wrData[CNT_W-1]));

  a_r8_cmf_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmfFlag) |-> $past(wrEn && addr == 2'd2 && !wrData[CNT_W-2]));

endmodule

bind prescaled_timer8 timer8_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .cnt(countQ), .cmpVal(cmpVal), .srcSel(dpCtl.srcSel),
  .ovfFlag(ovfFlag), .cmfFlag(cmfFlag)
);

// File: tb/prescaled_timer8_bench.sv
module prescaled_timer8_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       evtIn = 1'b0;
  logic       subClk = 1'b0;
  logic       irqOvf;

  int checks = 0;
  int fails = 0;
  bit doneFlag = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  prescaled_timer8 u_prescaled_timer8 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .subClk(subClk),
    .irqOvf(irqOvf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #2 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic evtPulse();
    @(negedge clk); evtIn = 1'b1;
    repeat (3) @(negedge clk);
    evtIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic subPulse();
    @(negedge clk); subClk = 1'b1;
    repeat (3) @(negedge clk);
    subClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // rising event timed so its count step lands in the same edge as a status write
  task automatic pulseWithStatusWrite(input logic [7:0] d);
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 2'd2; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    repeat (2) @(negedge clk);
    evtIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] v, c0, c1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rdReg(2'd0, v); check("R1 ctrl", v, 8'h00);
    rdReg(2'd1, v); check("R1 cmp", v, 8'hFF);
    rdReg(2'd2, v); check("R1 stat", v, 8'h00);
    rdReg(2'd3, v); check("R1 count", v, 8'h00);
    check("R1 irq", irqOvf, 1'b0);

    // R2 prescaled system clock, R11 control readback
    for (int s = 4; s <= 6; s++) begin
      wrReg(2'd0, 8'(s));
      rdReg(2'd0, v); check("R11 ctrl readback", v, 8'(s));
      rdReg(2'd3, c0);
      repeat (126) @(negedge clk);
      rdReg(2'd3, c1);
      check("R2 divided count", 8'(c1 - c0), (s == 4) ? 8'd4 : (s == 5) ? 8'd8 : 8'd32);
    end

    // R3 sub-clock divide by four
    wrReg(2'd0, 8'h07);
    rdReg(2'd3, c0);
    repeat (16) subPulse();
    rdReg(2'd3, c1);
    check("R3 sub count", 8'(c1 - c0), 8'd4);

    // R5 reserved code
    wrReg(2'd0, 8'h0B);
    rdReg(2'd3, c0);
    repeat (3) evtPulse();
    repeat (8) subPulse();
    repeat (100) @(negedge clk);
    rdReg(2'd3, c1);
    check("R5 reserved hold", c1, c0);

    // R4 event codes, rising polarity
    for (int s = 0; s <= 2; s++) begin
      wrReg(2'd0, 8'h08 | 8'(s));
      rdReg(2'd3, c0);
      repeat (4) evtPulse();
      rdReg(2'd3, c1);
      check("R4 event count", 8'(c1 - c0), 8'd4);
    end

    // R4 edge polarity
    for (int pol = 0; pol <= 1; pol++) begin
      wrReg(2'd0, pol ? 8'h08 : 8'h00);
      rdReg(2'd3, c0);
      @(negedge clk); evtIn = 1'b1;
      repeat (6) @(negedge clk);
      rdReg(2'd3, c1);
      check("R4 on rise", 8'(c1 - c0), pol ? 8'd1 : 8'd0);
      evtIn = 1'b0;
      repeat (6) @(negedge clk);
      rdReg(2'd3, v);
      check("R4 on fall", 8'(v - c1), pol ? 8'd0 : 8'd1);
    end

    // R7 match flag
    wrReg(2'd0, 8'h08);
    rdReg(2'd3, c0);
    wrReg(2'd1, 8'(c0 + 8'd3));
    repeat (2) evtPulse();
    rdReg(2'd2, v); check("R7 not yet matched", v[6], 1'b0);
    evtPulse();
    rdReg(2'd2, v); check("R7 match set", v[6], 1'b1);

    // R9 set and clear in the same cycle (flag already armed by the read above)
    rdReg(2'd3, c0);
    wrReg(2'd1, 8'(c0 + 8'd1));
    pulseWithStatusWrite(8'h80);
    rdReg(2'd3, c1); check("R9 step happened", c1, 8'(c0 + 8'd1));
    rdReg(2'd2, v);  check("R9 set wins", v[6], 1'b1);
    wrReg(2'd2, 8'h80);
    rdReg(2'd2, v);  check("R8 read then write 0 clears", v[6], 1'b0);

    // R6 overflow, R10 interrupt, R8 handshake
    wrReg(2'd2, 8'hC1);
    rdReg(2'd3, c0);
    for (int i = 0; i < 255 - int'(c0); i++) evtPulse();
    rdReg(2'd3, v); check("R6 at top", v, 8'hFF);
    check("R10 irq before wrap", irqOvf, 1'b0);
    evtPulse();
    @(negedge clk);
    check("R10 irq after wrap", irqOvf, 1'b1);
    wrReg(2'd2, 8'h41);
    @(negedge clk); check("R8 write 0 without read", irqOvf, 1'b1);
    wrReg(2'd2, 8'hC0);
    @(negedge clk); check("R10 enable off", irqOvf, 1'b0);
    wrReg(2'd2, 8'hC1);
    @(negedge clk); check("R10 enable on", irqOvf, 1'b1);
    rdReg(2'd2, v); check("R6 status", v, 8'h81);
    rdReg(2'd3, v); check("R6 wrapped count", v, 8'h00);
    wrReg(2'd2, 8'hC1);
    @(negedge clk); check("R8 write 1 no effect", irqOvf, 1'b1);
    wrReg(2'd2, 8'h41);
    @(negedge clk); check("R8 clear overflow", irqOvf, 1'b0);
    rdReg(2'd2, v); check("R8 status after clear", v, 8'h01);

    finishRun();
  end

endmodule